// File: doc/BRIEF.md
# Sequential Signed-Magnitude Multiplier

This block multiplies two unsigned magnitudes that each carry a separate sign bit. A product magnitude twice the operand width comes out, with its own sign. The magnitude is formed by shift-and-add, one multiplier bit per clock. The multiplicand is held in a fixed register. The multiplier sits in the low-half register. The partial product grows in the high-half register. On each step the lowest multiplier bit decides whether the multiplicand is added to the high half. After that, the carry, the high half and the low half move one place to the right together. Over the run, the product's low bits replace the multiplier in the low-half register.

The sign is handled apart from the magnitude. It is the exclusive-OR of the two operand signs and is captured when the operation is accepted. A one-cycle start strobe launches an operation while the block is idle. `busy_o` covers the stepping cycles. `done_o` marks the cycle in which the result becomes final. The result then stays on the outputs until the next accepted start.

Top module: `smm_mult`

## Requirements
- R1: After reset, busy_o, done_o, prod_sign_o and every bit of prod_mag_o are 0.
- R2: A start_i sampled high while busy_o is low is accepted. busy_o is then high for exactly WIDTH cycles, beginning in the cycle after the accepting edge.
- R3: done_o is high for exactly one cycle: the first cycle after busy_o falls. busy_o is low in that cycle.
- R4: When done_o is high, prod_mag_o equals the unsigned product of mcand_mag_i and mplier_mag_i as sampled at the accepting edge. Bits [2*WIDTH-1:WIDTH] are the high half and bits [WIDTH-1:0] are the low half.
- R5: From the cycle after an accepted start, prod_sign_o equals mcand_sign_i XOR mplier_sign_i as sampled at that edge. This holds even when the magnitude is zero.
- R6: A start_i sampled while busy_o is high is ignored. The run in progress, its length and its result are unchanged.
- R7: While the block is idle after an operation, prod_mag_o and prod_sign_o hold their final values until the next accepted start.
- R8: A start_i presented in the same cycle as done_o is accepted, so operations can run back to back with no gap.
- R9: A multiplier bit of 0 adds nothing, so a zero multiplier or a zero multiplicand gives a zero magnitude. A maximum magnitude times a maximum magnitude gives (2^WIDTH-1)^2 without loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Operation request, honoured only while idle |
| mcand_mag_i | input | WIDTH | Multiplicand magnitude |
| mcand_sign_i | input | 1 | Multiplicand sign, 1 = negative |
| mplier_mag_i | input | WIDTH | Multiplier magnitude |
| mplier_sign_i | input | 1 | Multiplier sign, 1 = negative |
| busy_o | output | 1 | High during the WIDTH stepping cycles |
| done_o | output | 1 | One-cycle pulse when the result is final |
| prod_mag_o | output | 2*WIDTH | Product magnitude, high half over low half |
| prod_sign_o | output | 1 | Product sign |

## Verification
A step counter that is off by one shows at the ports right away. busy_o falls one cycle early or late, and done_o lands in the wrong cycle, which the bench catches in the cycle it happens. A wrong add decision, a lost carry or a misrouted shift bit shows only when done_o rises. At that point the magnitude differs from the reference product, within WIDTH+1 cycles of the start. The corner operands (zero, one, all ones) make carries and skipped adds visible. A start that sneaks in mid-run shows as a shortened busy window or a product of the wrong operands.

// File: rtl/smm_pkg.sv
package smm_pkg;
  typedef struct packed {
    logic load;  // capture operands, clear high half
    logic step;  // one add-and-shift step
  } smm_ctl_t;
endpackage

// File: rtl/smm_addstep.sv
module smm_addstep #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic             add_en_i,
  output logic [WIDTH:0]   sum_o
);
  always_comb begin
    sum_o = {1'b0, acc_i};
    if (add_en_i) sum_o = {1'b0, acc_i} + {1'b0, mcand_i};
  end
endmodule

// File: rtl/smm_ctrl.sv
module smm_ctrl
  import smm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  output smm_ctl_t ctl_o,
  output logic     busy_o,
  output logic     done_o
);
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(WIDTH);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign busy_o     = (cnt_q != '0);
  assign done_o     = done_q;
  assign ctl_o.load = start_i & ~busy_o;
  assign ctl_o.step = busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= busy_o && (cnt_q == CNT_ONE);
      if (ctl_o.load)  cnt_q <= CNT_INIT;
      else if (busy_o) cnt_q <= cnt_q - CNT_ONE;
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_o);
  // R6
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (cnt_q == $past(cnt_q) - CNT_ONE));
  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_INIT);
  // R2
  start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o.load |=> (cnt_q == CNT_INIT));
endmodule

// File: rtl/smm_datapath.sv
module smm_datapath
  import smm_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  smm_ctl_t         ctl_i,
  input  logic [WIDTH-1:0] mcand_mag_i,
  input  logic             mcand_sign_i,
  input  logic [WIDTH-1:0] mplier_mag_i,
  input  logic             mplier_sign_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o,
  output logic             sign_o
);
  logic [WIDTH-1:0] mcand_q;  // multiplicand
  logic [WIDTH-1:0] hi_q;     // partial product high half
  logic [WIDTH-1:0] lo_q;     // multiplier, becomes product low half
  logic             sign_q;
  logic [WIDTH:0]   sum;      // sum[WIDTH] is the carry into the shift

  smm_addstep #(.WIDTH(WIDTH)) u_add (
    .acc_i    (hi_q),
    .mcand_i  (mcand_q),
    .add_en_i (lo_q[0]),
    .sum_o    (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      hi_q    <= '0;
      lo_q    <= '0;
      sign_q  <= 1'b0;
    end else if (ctl_i.load) begin
      mcand_q <= mcand_mag_i;
      hi_q    <= '0;
      lo_q    <= mplier_mag_i;
      sign_q  <= mcand_sign_i ^ mplier_sign_i;
    end else if (ctl_i.step) begin
      // carry, high half and low half shift right as one chain
      hi_q <= sum[WIDTH:1];
      lo_q <= {sum[0], lo_q[WIDTH-1:1]};
    end
  end

  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
  assign sign_o = sign_q;

  // R2
  load_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.load |=> (hi_q == '0));
  // R5
  sign_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.load |=> (sign_q == $past(mcand_sign_i ^ mplier_sign_i)));
  // R9
  no_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_i.step && !ctl_i.load && !lo_q[0]) |=> (hi_q == ($past(hi_q) >> 1)));
  // R7
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.step && !ctl_i.load) |=> ($stable(hi_q) && $stable(lo_q) && $stable(sign_q)));
  // R6
  mcand_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.step |=> $stable(mcand_q));
endmodule

// File: rtl/smm_mult.sv
module smm_mult
  import smm_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int PW = 2 * WIDTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] mcand_mag_i,
  input  logic             mcand_sign_i,
  input  logic [WIDTH-1:0] mplier_mag_i,
  input  logic             mplier_sign_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [PW-1:0]    prod_mag_o,
  output logic             prod_sign_o
);
  smm_ctl_t         ctl;
  logic [WIDTH-1:0] hi;
  logic [WIDTH-1:0] lo;

  smm_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .ctl_o   (ctl),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  smm_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .ctl_i         (ctl),
    .mcand_mag_i   (mcand_mag_i),
    .mcand_sign_i  (mcand_sign_i),
    .mplier_mag_i  (mplier_mag_i),
    .mplier_sign_i (mplier_sign_i),
    .hi_o          (hi),
    .lo_o          (lo),
    .sign_o        (sign_o_int)
  );

  logic sign_o_int;
  assign prod_mag_o  = {hi, lo};
  assign prod_sign_o = sign_o_int;

  // R4
  done_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) && !busy_o));
endmodule

// File: tb/smm_mult_tb_top.sv
module smm_mult_tb_top;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  a_mag = '0;
  logic          a_sgn = 1'b0;
  logic [W-1:0]  b_mag = '0;
  logic          b_sgn = 1'b0;
  logic          busy;
  logic          done;
  logic [PW-1:0] prod;
  logic          psign;

  smm_mult #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .mcand_mag_i(a_mag), .mcand_sign_i(a_sgn),
    .mplier_mag_i(b_mag), .mplier_sign_i(b_sgn),
    .busy_o(busy), .done_o(done), .prod_mag_o(prod), .prod_sign_o(psign)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  int            m_cnt = 0;
  bit            m_done = 0;
  bit            m_valid = 0;  // magnitude final and held
  bit            m_has_sign = 0;
  bit            m_sign = 0;
  logic [PW-1:0] m_prod = '0;
  logic [PW-1:0] m_pend = '0;
  bit            m_pend_sign = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_done = 0; m_valid = 0; m_has_sign = 0;
      m_sign = 0; m_prod = '0;
    end else begin
      cycles++;
      m_done = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_done = 1; m_valid = 1; m_prod = m_pend;
        end
      end else if (start) begin
        m_cnt = W;
        m_pend = PW'(a_mag) * PW'(b_mag);
        m_sign = a_sgn ^ b_sgn;
        m_has_sign = 1;
        m_valid = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [PW-1:0] act,
                     input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (m_cnt > 0), "R2 busy window", PW'(busy), PW'(m_cnt > 0));
      chk(done == m_done, "R3 done pulse", PW'(done), PW'(m_done));
      if (m_done)
        chk(prod == m_prod, "R4 product at done", prod, m_prod);
      else if (m_valid)
        chk(prod == m_prod, "R7 product held", prod, m_prod);
      if (m_has_sign)
        chk(psign == m_sign, "R5 sign", PW'(psign), PW'(m_sign));
    end
  end

  task automatic issue(input logic [W-1:0] a, input bit as, input logic [W-1:0] b,
                       input bit bs);
    @(negedge clk);
    a_mag = a; a_sgn = as; b_mag = b; b_sgn = bs; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (m_cnt > 0 || m_done) @(negedge clk);
  endtask

  task automatic run(input logic [W-1:0] a, input bit as, input logic [W-1:0] b,
                     input bit bs);
    wait_idle();
    issue(a, as, b, bs);
    wait_idle();
    repeat (2) @(negedge clk);
  endtask

  localparam logic [W-1:0] MAXV = {W{1'b1}};

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !psign && prod == '0, "R1 reset state",
        {busy, done, psign, prod[PW-4:0]}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 corner operands
    run('0, 1'b0, 8'd77, 1'b1);
    run(8'd91, 1'b1, '0, 1'b1);
    run(8'd1, 1'b0, 8'd1, 1'b0);
    run(MAXV, 1'b1, MAXV, 1'b0);
    run(MAXV, 1'b0, 8'd1, 1'b1);
    run(8'd1, 1'b1, MAXV, 1'b1);
    // R5 zero magnitude keeps the XOR sign
    run('0, 1'b1, '0, 1'b0);

    // R6 start while busy is ignored
    wait_idle();
    issue(8'd13, 1'b0, 8'd11, 1'b1);
    repeat (3) @(negedge clk);
    a_mag = 8'd200; b_mag = 8'd200; a_sgn = 1'b0; b_sgn = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R6 run continues", PW'(busy), PW'(1));
    wait_idle();
    chk(prod == PW'(143), "R6 original result", prod, PW'(143));
    chk(psign == 1'b1, "R6 original sign", PW'(psign), PW'(1));

    // R8 back to back
    wait_idle();
    issue(8'd25, 1'b0, 8'd9, 1'b0);
    while (!m_done) @(negedge clk);
    a_mag = 8'd200; b_mag = 8'd150; a_sgn = 1'b1; b_sgn = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R8 accepted with done", PW'(busy), PW'(1));
    wait_idle();
    chk(prod == PW'(30000), "R8 second result", prod, PW'(30000));

    // R4 random operands
    for (int i = 0; i < 60; i++)
      run(W'($urandom), 1'($urandom), W'($urandom), 1'($urandom));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule